// File: doc/BRIEF.md
# Super-Pixel Hit Packet Former

This block serves one super-pixel: a fixed 2-column by 4-row group of binary pixels whose shared logic sits at the centre of the group. Each clock cycle stands for one bunch crossing. Every pixel that fires in a crossing sets its bit in an 8-bit hitmap. The block then builds one packet from that hitmap, the super-pixel address and the 9-bit bunch-crossing timestamp. The address and the time are therefore sent once for the whole group, not once for each pixel.

A packet is offered to the column readout bus through a valid/ready handshake as soon as it is formed. No trigger is needed. The block holds at most two packets in a small buffer shared by the group. When both entries are occupied, new hits are dropped and a saturating overflow counter goes up.

Top module: `sp_packet_former`

## Requirements
- R1: A crossing in which no pixel strobe is high forms no packet and leaves the buffer contents unchanged.
- R2: A crossing with at least one pixel strobe high forms exactly one packet when buffer space is available. That packet is visible on the output no earlier than the next cycle.
- R3: The packet is 30 bits wide. Bits [29:17] hold the super-pixel address. Bits [16:8] hold the timestamp sampled in the hit cycle. Bits [7:0] hold the hitmap, where bit i equals strobe i and pixel i sits at row i/2 and column i%2.
- R4: Packets leave in the order in which they were formed, oldest first.
- R5: At most two packets are held. A new packet is accepted when fewer than two are held, or when a handshake takes place in the same cycle.
- R6: An entry is freed only in a cycle where both valid and ready are high. While valid is high and ready is low, the offered packet stays unchanged.
- R7: A crossing with hits that finds the buffer full, with no handshake in that cycle, drops the packet and adds one to the overflow counter.
- R8: The overflow counter saturates at its maximum value (255). Only reset clears it.
- R9: After reset, valid is low and the overflow counter reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch-crossing clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hit_i | input | 8 | Binary hit strobes, one per pixel |
| bcid_i | input | 9 | Low bits of the chip bunch counter |
| sp_addr_i | input | 13 | Super-pixel address of this group |
| pkt_ready_i | input | 1 | Readout bus can take a packet |
| pkt_valid_o | output | 1 | A packet is offered |
| pkt_data_o | output | 30 | Offered packet: address, timestamp, hitmap |
| ovf_cnt_o | output | 8 | Saturating count of dropped packets |

## Verification
The hardest condition to reach is the exact cycle in which the buffer is full, a new hit arrives and a handshake frees an entry at the same moment. In that cycle the packet must be accepted, not dropped. The stimulus holds ready low to fill the buffer, then raises it while the hit strobes stay busy. Randomised phases with partly asserted ready hit this edge many times. A long stretch with ready held low, spanning more than 255 hit crossings, drives the overflow counter into saturation.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int SP_COLS = 2;
  localparam int SP_ROWS = 4;
  localparam int NPIX    = SP_COLS * SP_ROWS;
  localparam int ADDR_W  = 13;
  localparam int BCID_W  = 9;
  localparam int PKT_W   = ADDR_W + BCID_W + NPIX;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [BCID_W-1:0] bcid;
    logic [NPIX-1:0]   map;
  } sp_pkt_t;
endpackage

// File: rtl/sp_hit_merge.sv
module sp_hit_merge
  import sp_pkg::*;
(
  input  logic [NPIX-1:0]   hit_i,
  input  logic [BCID_W-1:0] bcid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output sp_pkt_t           pkt_o,
  output logic              any_o
);
  logic [SP_ROWS-1:0] row_any;
  logic [NPIX-1:0]    map;

  // pixel index = row * SP_COLS + col
  for (genvar r = 0; r < SP_ROWS; r++) begin : g_row
    for (genvar c = 0; c < SP_COLS; c++) begin : g_col
      assign map[r*SP_COLS+c] = hit_i[r*SP_COLS+c];
    end
    assign row_any[r] = |hit_i[r*SP_COLS +: SP_COLS];
  end

  assign any_o = |row_any;

  always_comb begin
    pkt_o.addr = addr_i;
    pkt_o.bcid = bcid_i;
    pkt_o.map  = map;
  end
endmodule

// File: rtl/sp_pkt_fifo.sv
module sp_pkt_fifo #(
  parameter int DEPTH = 2,
  parameter int WIDTH = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             drop_o,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [WIDTH-1:0] data_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic pop, accept;

  assign valid_o = cnt_q != '0;
  assign data_o  = mem_q[rd_q];
  assign pop     = valid_o && ready_i;
  assign accept  = push_i && ((cnt_q < CNT_W'(DEPTH)) || pop);
  assign drop_o  = push_i && !accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (accept) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop)    rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({accept, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (accept && wr_q == PTR_W'(i)) mem_q[i] <= data_i;
    end
  end

  a_r5_depth_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  a_r6_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o));
  a_r5_room_accepts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && cnt_q < CNT_W'(DEPTH) |-> !drop_o);
endmodule

// File: rtl/sp_ovf_counter.sv
module sp_ovf_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (inc_i && ~&cnt_q)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r7_ovf_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && ~&cnt_q |=> cnt_o == $past(cnt_o) + 1'b1);
  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i || &cnt_q |=> $stable(cnt_o));
endmodule

// File: rtl/sp_packet_former.sv
module sp_packet_former
  import sp_pkg::*;
#(
  parameter int BUF_DEPTH = 2,
  parameter int OVF_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPIX-1:0]   hit_i,
  input  logic [BCID_W-1:0] bcid_i,
  input  logic [ADDR_W-1:0] sp_addr_i,
  input  logic              pkt_ready_i,
  output logic              pkt_valid_o,
  output logic [PKT_W-1:0]  pkt_data_o,
  output logic [OVF_W-1:0]  ovf_cnt_o
);
  sp_pkt_t new_pkt;
  logic    any_hit, drop;

  sp_hit_merge u_merge (
    .hit_i  (hit_i),
    .bcid_i (bcid_i),
    .addr_i (sp_addr_i),
    .pkt_o  (new_pkt),
    .any_o  (any_hit)
  );

  sp_pkt_fifo #(.DEPTH(BUF_DEPTH), .WIDTH(PKT_W)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (any_hit),
    .data_i  (new_pkt),
    .drop_o  (drop),
    .valid_o (pkt_valid_o),
    .ready_i (pkt_ready_i),
    .data_o  (pkt_data_o)
  );

  sp_ovf_counter #(.W(OVF_W)) u_ovf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (drop),
    .cnt_o  (ovf_cnt_o)
  );

  a_r1_no_empty_packet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> pkt_data_o[NPIX-1:0] != '0);
  a_r2_hit_offers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_hit && !drop |=> pkt_valid_o);
  a_r7_drop_only_hits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |-> hit_i != '0 && !(pkt_valid_o && pkt_ready_i));
endmodule

// File: tb/tb_sp_packet_former.sv
module tb_sp_packet_former;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  hit_i = '0;
  logic [8:0]  bcid_i = '0;
  logic [12:0] sp_addr_i = 13'h0a5;
  logic        pkt_ready_i = 1'b0;
  logic        pkt_valid_o;
  logic [29:0] pkt_data_o;
  logic [7:0]  ovf_cnt_o;

  int checks = 0;
  int errors = 0;
  logic [29:0] q[$];
  int ovf_m = 0;
  logic [11:0] bx = '0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  sp_packet_former dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R2/R5 valid", 32'(pkt_valid_o), 32'(q.size() != 0));
    if (q.size() != 0) chk("R3/R4 data", 32'(pkt_data_o), 32'(q[0]));
    chk("R7/R8 overflow", 32'(ovf_cnt_o), 32'(ovf_m));
  endtask

  // at negedge: check state, drive next crossing, advance model
  task automatic step(logic [7:0] h, logic rdy);
    @(negedge clk_i);
    compare();
    hit_i = h;
    pkt_ready_i = rdy;
    bx = bx + 1'b1;
    bcid_i = bx[8:0];
    begin
      bit pop;
      pop = (q.size() != 0) && rdy;
      if (h != '0) begin
        if (q.size() < 2 || pop) begin
          if (pop) void'(q.pop_front());
          q.push_back({sp_addr_i, bcid_i, h});
        end else begin
          if (ovf_m < 255) ovf_m++;
        end
      end else if (pop) void'(q.pop_front());
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R9 reset valid", 32'(pkt_valid_o), 0);
    chk("R9 reset ovf", 32'(ovf_cnt_o), 0);
    rst_ni = 1'b1;
    // R1: idle crossings form nothing
    for (int i = 0; i < 5; i++) step(8'h00, 1'b1);
    // R2/R3: single pixel per position
    for (int i = 0; i < 8; i++) begin
      step(8'h01 << i, 1'b1);
      step(8'h00, 1'b1);
    end
    // R4/R6: stall, fill, then drain in order
    step(8'h81, 1'b0);
    step(8'h3c, 1'b0);
    step(8'h00, 1'b0);
    step(8'h00, 1'b0);
    // R7: full and no handshake -> drop
    step(8'hff, 1'b0);
    // R5: full, handshake with new hit -> accepted
    step(8'h42, 1'b1);
    step(8'h00, 1'b1);
    step(8'h00, 1'b1);
    step(8'h00, 1'b1);
    // random traffic, different address
    sp_addr_i = 13'h1f3c;
    for (int i = 0; i < 2000; i++)
      step(($urandom % 3 == 0) ? 8'h00 : 8'($urandom), 1'($urandom % 2));
    // R8: saturate the overflow counter with ready low
    for (int i = 0; i < 300; i++) step(8'($urandom) | 8'h01, 1'b0);
    step(8'h00, 1'b0);
    chk("R8 saturated", 32'(ovf_cnt_o), 32'd255);
    for (int i = 0; i < 50; i++) step(8'($urandom), 1'($urandom % 2));
    // R8: only reset clears
    @(negedge clk_i);
    rst_ni = 1'b0;
    q.delete();
    ovf_m = 0;
    @(negedge clk_i);
    chk("R9 reset again valid", 32'(pkt_valid_o), 0);
    chk("R8/R9 reset clears ovf", 32'(ovf_cnt_o), 0);
    rst_ni = 1'b1;
    hit_i = '0;
    for (int i = 0; i < 20; i++) step(8'($urandom), 1'b1);
    step(8'h00, 1'b1);
    step(8'h00, 1'b1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule